// File: doc/BRIEF.md
# Parallel Flash Programming Command Sequencer

This block runs the parallel programming interface of an on-chip program store. An external programmer presents a 4-bit operation code, an address, a data byte and an active-low program strobe. Write-class operations start on the falling edge of the strobe. The operation code, address and data are captured at that edge. The block then updates a behavioural model of the program array, the encryption (security) array, the cumulative lock level and the watchdog power-on default in the option register. Read-class operations run while the strobe is held high. They return one byte on a registered output with an output-enable.

Erasing operations (mass erase and option erase) need a long strobe, counted in clock cycles. If the strobe is released early, the operation is abandoned and an error flag is raised. Byte-level programming commits when the strobe is released, or when the short-pulse cycle limit is reached, whichever comes first. Both limits are parameters. Their defaults correspond to about 828 ms and 100 µs at 100 MHz, and a bench can shorten them.

Top module: `flash_pgm_seq`

## Requirements
- R1: The operation code is read with bit 3 as the first mode pin. The codes are: 1000 mass erase, 0111 byte write, 0011 byte read, 0101 encryption-array write, 1111 lock level 1, 1100 lock level 2, 1010 lock level 3, 0001 lock read, 0100 option write, 1001 option erase, 0000 identification read. A byte written with 0111 at an address reads back with 0011 at that address while the store is unlocked.
- R2: After reset, busy, the error flag and the output-enable are 0. Every program location reads FFh, the lock read returns 07h, and the option register reads 00h.
- R3: A mass erase held for the full long count sets every program and encryption location to FFh and returns all three lock bits to 1.
- R4: Lock levels are cumulative. Level 1 clears lock bit 1 only. Level 2 clears lock bits 2 and 1. Level 3 clears all three. Only a mass erase sets a lock bit back to 1.
- R5: A lock read returns lock bits 3, 2, 1 on output bits 2, 1, 0, with the upper five bits at 0.
- R6: While any lock bit is 0, a byte read returns FFh.
- R7: An identification read returns the manufacturer ID at address 30h, the device ID at 31h, the device extension at 60h, and the option register at FCh (watchdog default on bit 3, other bits 0). Any other address returns FFh.
- R8: An option write stores data bit 3 as the watchdog default. An option erase held for the full long count clears it.
- R9: If a long operation sees the strobe high before its count completes, it leaves all state unchanged and sets the error flag. The flag stays set until the next operation is accepted.
- R10: Busy rises on the clock after an accepted strobe fall and stays high until the operation finishes. Changes to the operation code, address or data while busy have no effect.
- R11: The output-enable and read data appear one clock after a read code is presented with the strobe high and busy low. At any other time the output-enable is 0 and the data output is 00h.
- R12: A short operation commits when the strobe rises, or after the short cycle limit while the strobe is still low, whichever comes first. Busy then falls.
- R13: A strobe fall with an unassigned code (0010, 0110, 1011, 1101, 1110) or with a read code starts nothing: busy stays 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeCode | input | 4 | Operation code, bit 3 first mode pin |
| addrIn | input | ADDR_W | Address bus |
| dataIn | input | 8 | Data to program |
| strobeN | input | 1 | Active-low program strobe, idle high |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Read data valid / drive enable |
| busy | output | 1 | Operation in progress |
| abortErr | output | 1 | Last long operation was cut short |

## Verification
Some properties are checked on every clock edge. The lock bits never rise except after a mass erase, and they always keep their cumulative order. A locked store never returns a program byte. An early strobe release on a long operation always ends busy and raises the error flag. The captured operation stays stable while busy, and a short operation never counts past its limit. Other behaviours show only in the bench scenarios, because they need the stored contents to be observed through the read path later: write-then-read data, erase results, identification values, the effect of an aborted erase, and the fact that codes changed while busy or unassigned codes leave nothing behind.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

  localparam logic [3:0] OP_MASS_ERASE = 4'b1000;
  localparam logic [3:0] OP_WR_BYTE    = 4'b0111;
  localparam logic [3:0] OP_RD_BYTE    = 4'b0011;
  localparam logic [3:0] OP_WR_ENC     = 4'b0101;
  localparam logic [3:0] OP_LOCK1      = 4'b1111;
  localparam logic [3:0] OP_LOCK2      = 4'b1100;
  localparam logic [3:0] OP_LOCK3      = 4'b1010;
  localparam logic [3:0] OP_RD_LOCK    = 4'b0001;
  localparam logic [3:0] OP_WR_OPT     = 4'b0100;
  localparam logic [3:0] OP_ER_OPT     = 4'b1001;
  localparam logic [3:0] OP_RD_ID      = 4'b0000;

  typedef enum logic [1:0] {RD_NONE, RD_PROG, RD_LOCK, RD_ID} rdSel_e;

  // strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic       wrByte;
    logic       wrEnc;
    logic       wrOpt;
    logic       eraseOpt;
    logic       massErase;
    logic [1:0] lockLevel;  // 0 none, 1..3 cumulative level
  } cmd_t;

endpackage

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import flash_pgm_pkg::*;
#(
  parameter int unsigned LONG_CNT  = 82_800_000,
  parameter int unsigned SHORT_CNT = 10_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] modeCode,
  input  logic       strobeN,
  output logic       busy,
  output logic       abortErr,
  output logic       capture,
  output cmd_t       cmd,
  output rdSel_e     rdSel
);

  localparam int unsigned CNT_W = $clog2(LONG_CNT + 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CNT);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CNT);

  logic             strobeQ;
  logic             busyQ;
  logic             errQ;
  logic [3:0]       opQ;
  logic [CNT_W-1:0] cnt;
  logic             startOp, finish, abortNow, longOp;

  function automatic logic isWrite(input logic [3:0] code);
    case (code)
      OP_MASS_ERASE, OP_WR_BYTE, OP_WR_ENC, OP_LOCK1, OP_LOCK2,
      OP_LOCK3, OP_WR_OPT, OP_ER_OPT: isWrite = 1'b1;
      default:                        isWrite = 1'b0;
    endcase
  endfunction

  assign longOp   = (opQ == OP_MASS_ERASE) || (opQ == OP_ER_OPT);
  assign startOp  = !busyQ && strobeQ && !strobeN && isWrite(modeCode);
  assign abortNow = busyQ && strobeN && longOp;
  assign finish   = busyQ && (strobeN ? !longOp
                                      : (cnt == (longOp ? LONG_LIM : SHORT_LIM)));
  assign capture  = startOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= 1'b1;
      busyQ   <= 1'b0;
      errQ    <= 1'b0;
      opQ     <= '0;
      cnt     <= '0;
    end else begin
      strobeQ <= strobeN;
      if (startOp) begin
        busyQ <= 1'b1;
        errQ  <= 1'b0;
        opQ   <= modeCode;
        cnt   <= CNT_W'(1);
      end else if (busyQ) begin
        if (abortNow || finish) begin
          busyQ <= 1'b0;
          errQ  <= abortNow;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd = '0;
    if (finish) begin
      case (opQ)
        OP_MASS_ERASE: cmd.massErase = 1'b1;
        OP_WR_BYTE:    cmd.wrByte    = 1'b1;
        OP_WR_ENC:     cmd.wrEnc     = 1'b1;
        OP_LOCK1:      cmd.lockLevel = 2'd1;
        OP_LOCK2:      cmd.lockLevel = 2'd2;
        OP_LOCK3:      cmd.lockLevel = 2'd3;
        OP_WR_OPT:     cmd.wrOpt     = 1'b1;
        OP_ER_OPT:     cmd.eraseOpt  = 1'b1;
        default:       cmd           = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (!busyQ && strobeN) begin
      case (modeCode)
        OP_RD_BYTE: rdSel = RD_PROG;
        OP_RD_LOCK: rdSel = RD_LOCK;
        OP_RD_ID:   rdSel = RD_ID;
        default:    rdSel = RD_NONE;
      endcase
    end
  end

  assign busy     = busyQ;
  assign abortErr = errQ;

  // R10: an accepted strobe fall raises busy on the next clock
  assert_busy_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    startOp |=> busy);

  // R10: the captured operation does not follow the pins while busy
  assert_op_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !finish && !abortNow) |=> $stable(opQ));

  // R9: early release of a long strobe ends the operation with the error flag
  assert_abort_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && strobeN && longOp) |=> (!busy && abortErr));

  // R12: a short operation never counts beyond its limit
  assert_short_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !longOp) |-> (cnt <= SHORT_LIM));

endmodule

// File: rtl/flash_pgm_data.sv
module flash_pgm_data
  import flash_pgm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned MEM_AW  = 6,
  parameter logic [7:0]  MFG_ID  = 8'hDA,
  parameter logic [7:0]  DEV_ID  = 8'h40,
  parameter logic [7:0]  DEV_EXT = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  cmd_t              cmd,
  input  rdSel_e            rdSel,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam int unsigned DEPTH = 1 << MEM_AW;
  localparam logic [ADDR_W-1:0] A_MFG = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_OPT = ADDR_W'(8'hFC);

  logic [7:0]        progMem [DEPTH];
  logic [7:0]        encMem  [DEPTH];
  logic [2:0]        lockBits;   // [2]=level-3 bit, [0]=level-1 bit, 1 = open
  logic              wdDefault;
  logic [MEM_AW-1:0] addrQ;
  logic [7:0]        dataQ;
  logic [7:0]        rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        progMem[i] <= 8'hFF;
        encMem[i]  <= 8'hFF;
      end
      lockBits  <= 3'b111;
      wdDefault <= 1'b0;
      addrQ     <= '0;
      dataQ     <= '0;
    end else begin
      if (capture) begin
        addrQ <= addrIn[MEM_AW-1:0];
        dataQ <= dataIn;
      end
      if (cmd.massErase) begin
        for (int i = 0; i < DEPTH; i++) begin
          progMem[i] <= 8'hFF;
          encMem[i]  <= 8'hFF;
        end
        lockBits <= 3'b111;
      end
      if (cmd.wrByte) progMem[addrQ] <= dataQ;
      if (cmd.wrEnc)  encMem[addrQ]  <= dataQ;
      for (int l = 0; l < 3; l++) begin
        if (l < int'(cmd.lockLevel)) lockBits[l] <= 1'b0;
      end
      if (cmd.wrOpt)    wdDefault <= dataQ[3];
      if (cmd.eraseOpt) wdDefault <= 1'b0;
    end
  end

  always_comb begin
    rdMux = 8'h00;
    case (rdSel)
      RD_PROG: rdMux = (&lockBits) ? progMem[addrIn[MEM_AW-1:0]] : 8'hFF;
      RD_LOCK: rdMux = {5'b0, lockBits};
      RD_ID: begin
        if      (addrIn == A_MFG) rdMux = MFG_ID;
        else if (addrIn == A_DEV) rdMux = DEV_ID;
        else if (addrIn == A_EXT) rdMux = DEV_EXT;
        else if (addrIn == A_OPT) rdMux = {4'b0, wdDefault, 3'b0};
        else                      rdMux = 8'hFF;
      end
      default: rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= 8'h00;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= rdMux;
      dataOe  <= (rdSel != RD_NONE);
    end
  end

  // R4: lock bits only fall, except through a mass erase
  assert_lock_monotonic_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.massErase |=> ((lockBits & ~$past(lockBits)) == 3'b000));

  // R4: a cleared higher level implies every lower level is cleared
  assert_lock_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!lockBits[2] |-> !lockBits[1]) and (!lockBits[1] |-> !lockBits[0]));

  // R6: a locked store never yields a program byte
  assert_locked_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == RD_PROG && lockBits != 3'b111) |=> (dataOe && dataOut == 8'hFF));

  // R3: a mass erase leaves the arrays blank and the store unlocked
  assert_erase_blank_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.massErase |=> (lockBits == 3'b111 && encMem[0] == 8'hFF &&
                       progMem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_pgm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MEM_AW    = 6,
  parameter int unsigned LONG_CNT  = 82_800_000,
  parameter int unsigned SHORT_CNT = 10_000,
  parameter logic [7:0]  MFG_ID    = 8'hDA,
  parameter logic [7:0]  DEV_ID    = 8'h40,
  parameter logic [7:0]  DEV_EXT   = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        modeCode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              strobeN,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              abortErr
);

  cmd_t   cmd;
  rdSel_e rdSel;
  logic   capture;

  flash_pgm_ctrl #(
    .LONG_CNT (LONG_CNT),
    .SHORT_CNT(SHORT_CNT)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeCode(modeCode),
    .strobeN (strobeN),
    .busy    (busy),
    .abortErr(abortErr),
    .capture (capture),
    .cmd     (cmd),
    .rdSel   (rdSel)
  );

  flash_pgm_data #(
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW),
    .MFG_ID (MFG_ID),
    .DEV_ID (DEV_ID),
    .DEV_EXT(DEV_EXT)
  ) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .capture(capture),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .cmd    (cmd),
    .rdSel  (rdSel),
    .dataOut(dataOut),
    .dataOe (dataOe)
  );

endmodule

// File: tb/flash_pgm_seq_tb_top.sv
module flash_pgm_seq_tb_top;

  localparam int LONG  = 20;
  localparam int SHORT = 6;
  localparam logic [3:0] IDLE = 4'b0010;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] modeCode = IDLE;
  logic [7:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic       strobeN = 1'b1;
  logic [7:0] dataOut;
  logic       dataOe, busy, abortErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] expQ[$];
  string      reqQ[$];

  always #5 clk = ~clk;

  flash_pgm_seq #(
    .ADDR_W(8), .MEM_AW(6), .LONG_CNT(LONG), .SHORT_CNT(SHORT),
    .MFG_ID(8'hDA), .DEV_ID(8'h40), .DEV_EXT(8'h01)
  ) dut_i (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .addrIn(addrIn),
    .dataIn(dataIn), .strobeN(strobeN), .dataOut(dataOut), .dataOe(dataOe),
    .busy(busy), .abortErr(abortErr)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop one expected item per output-enable cycle
  always @(negedge clk) begin
    if (rstN && dataOe) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R11 actual=%0h expected=no read pending", dataOut);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string r = reqQ.pop_front();
        check(r, int'(dataOut), int'(e));
      end
    end
  end

  task automatic readOp(input logic [3:0] code, input logic [7:0] a,
                        input logic [7:0] exp, input string req);
    @(negedge clk);
    modeCode = code; addrIn = a; strobeN = 1'b1;
    expQ.push_back(exp); reqQ.push_back(req);
    @(negedge clk);
    modeCode = IDLE;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] code, input logic [7:0] a,
                       input logic [7:0] d, input int lowCyc);
    @(negedge clk);
    modeCode = code; addrIn = a; dataIn = d; strobeN = 1'b0;
    repeat (lowCyc) @(negedge clk);
    strobeN = 1'b1; modeCode = IDLE;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 busy", busy, 0);
    check("R2 abortErr", abortErr, 0);
    check("R2 dataOe", dataOe, 0);
    readOp(4'b0011, 8'h00, 8'hFF, "R2 blank byte");
    readOp(4'b0001, 8'h40, 8'h07, "R2 lock open");
    readOp(4'b0000, 8'hFC, 8'h00, "R2 option");

    // R1 / R12 short write committed on rising strobe
    pulse(4'b0111, 8'h03, 8'hA5, 3);
    readOp(4'b0011, 8'h03, 8'hA5, "R1 write-read");

    // R12 write held beyond short limit: busy falls with strobe still low
    @(negedge clk);
    modeCode = 4'b0111; addrIn = 8'h0A; dataIn = 8'h5A; strobeN = 1'b0;
    @(negedge clk);
    check("R12 busy during short", busy, 1);
    repeat (12) @(negedge clk);
    check("R12 busy ends at limit", busy, 0);
    strobeN = 1'b1; modeCode = IDLE;
    repeat (3) @(negedge clk);
    readOp(4'b0011, 8'h0A, 8'h5A, "R12 limit write");

    // R10 pins changed while busy have no effect
    @(negedge clk);
    modeCode = 4'b0111; addrIn = 8'h05; dataIn = 8'h3C; strobeN = 1'b0;
    @(negedge clk);
    check("R10 busy after fall", busy, 1);
    modeCode = 4'b1000; addrIn = 8'h06; dataIn = 8'h77;
    repeat (2) @(negedge clk);
    strobeN = 1'b1;
    @(negedge clk);
    modeCode = IDLE;
    repeat (3) @(negedge clk);
    check("R10 busy done", busy, 0);
    readOp(4'b0011, 8'h05, 8'h3C, "R10 latched write");
    readOp(4'b0011, 8'h06, 8'hFF, "R10 ignored change");
    readOp(4'b0011, 8'h03, 8'hA5, "R10 no erase");

    // R7 identification reads
    readOp(4'b0000, 8'h30, 8'hDA, "R7 mfg");
    readOp(4'b0000, 8'h31, 8'h40, "R7 dev");
    readOp(4'b0000, 8'h60, 8'h01, "R7 ext");
    readOp(4'b0000, 8'h22, 8'hFF, "R7 other");

    // R8 option write
    pulse(4'b0100, 8'h00, 8'h08, 2);
    readOp(4'b0000, 8'hFC, 8'h08, "R8 option set");

    // R9 aborted option erase
    pulse(4'b1001, 8'h00, 8'h00, 4);
    check("R9 err after abort", abortErr, 1);
    check("R9 busy after abort", busy, 0);
    readOp(4'b0000, 8'hFC, 8'h08, "R9 option kept");

    // R8 full option erase, R9 flag clears
    pulse(4'b1001, 8'h00, 8'h00, LONG + 4);
    check("R9 err cleared", abortErr, 0);
    readOp(4'b0000, 8'hFC, 8'h00, "R8 option erased");

    // R9 aborted mass erase
    pulse(4'b1000, 8'h00, 8'h00, 5);
    check("R9 err mass abort", abortErr, 1);
    readOp(4'b0011, 8'h03, 8'hA5, "R9 array kept");

    pulse(4'b0101, 8'h01, 8'h12, 2);

    // R4 / R5 / R6 cumulative locks
    pulse(4'b1100, 8'h00, 8'h00, 2);
    readOp(4'b0001, 8'h40, 8'h04, "R5 level2");
    readOp(4'b0011, 8'h03, 8'hFF, "R6 locked read");
    pulse(4'b1111, 8'h00, 8'h00, 2);
    readOp(4'b0001, 8'h40, 8'h04, "R4 level1 after level2");
    pulse(4'b1010, 8'h00, 8'h00, 2);
    readOp(4'b0001, 8'h40, 8'h00, "R4 level3");

    // R3 full mass erase
    pulse(4'b1000, 8'h00, 8'h00, LONG + 4);
    check("R3 err clear", abortErr, 0);
    readOp(4'b0001, 8'h40, 8'h07, "R3 unlocked");
    readOp(4'b0011, 8'h03, 8'hFF, "R3 blank 03");
    readOp(4'b0011, 8'h0A, 8'hFF, "R3 blank 0A");

    pulse(4'b1111, 8'h00, 8'h00, 2);
    readOp(4'b0001, 8'h40, 8'h06, "R4 level1 only");

    // R13 unassigned code starts nothing
    @(negedge clk);
    modeCode = 4'b0110; strobeN = 1'b0;
    @(negedge clk);
    check("R13 no busy", busy, 0);
    strobeN = 1'b1; modeCode = IDLE;
    repeat (2) @(negedge clk);
    readOp(4'b0001, 8'h40, 8'h06, "R13 lock unchanged");

    // R11 read code with strobe low gives no output-enable
    @(negedge clk);
    modeCode = 4'b0011; addrIn = 8'h03; strobeN = 1'b0;
    @(negedge clk);
    check("R11 oe low strobe", dataOe, 0);
    check("R11 data zero", dataOut, 0);
    check("R13 read code no busy", busy, 0);
    strobeN = 1'b1; modeCode = IDLE;
    repeat (3) @(negedge clk);

    check("R11 queue drained", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule